// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of one read or write burst in a synchronous DRAM controller or memory model. A start pulse captures three things: a starting column, a burst-length code and an ordering bit. From the next clock edge on, the block presents one column per cycle. It raises a valid flag for the whole burst and a last flag on the final beat.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block that holds the start column, in either sequential or interleaved order. A full-page burst walks the whole 512-column row. It wraps from the top column back to column 0 and runs until a terminate input stops it. A new start pulse may arrive at any time and begins a fresh burst from a new column. A hold input models clock suspend and freezes everything while it is high.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `col_o` is 0 and `valid_o` and `last_o` are low.
- R2: A start pulse sampled with hold low makes `valid_o` high on the next cycle, and `col_o` then equals the sampled start column.
- R3: Length codes map to burst lengths as follows: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page. Codes 4, 5 and 6 behave as length 1. After the final beat of a fixed burst, `valid_o` is low on the following cycle.
- R4: With the ordering bit at 0 (sequential) and N = 2, 4 or 8, beat k shows the start column's upper bits unchanged. Its low log2(N) bits are (start + k) mod N.
- R5: With the ordering bit at 1 (interleaved) and a fixed length N, beat k shows the start column XOR k, where k affects only the low log2(N) bits.
- R6: In full-page mode beat k shows (start + k) mod 512, so column 511 is followed by column 0. The ordering bit has no effect in this mode.
- R7: `last_o` is high exactly on the final beat of a fixed burst. It is never high in full-page mode.
- R8: A terminate input sampled with hold low and no start makes `valid_o` low on the next cycle. When no burst is running, terminate has no effect.
- R9: While hold is high at a clock edge, `col_o`, `valid_o` and `last_o` keep their values, and start and terminate are ignored. When hold falls, the burst resumes from the beat where it stopped.
- R10: A start pulse during a running burst abandons the old burst and begins the new one on the next cycle. If terminate is high in the same cycle, start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a burst with the captured settings |
| start_col_i | input | 9 | Starting column of the burst |
| len_code_i | input | 3 | Burst-length code (see R3) |
| ilv_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| hold_i | input | 1 | Clock-suspend freeze |
| term_i | input | 1 | Stop a running burst |
| col_o | output | 9 | Column for the current beat |
| valid_o | output | 1 | A burst beat is being presented |
| last_o | output | 1 | Current beat is the final one of a fixed burst |

## Verification
Each fixed length is run in both orderings, with start columns that sit at the bottom, in the middle and near the top of their aligned block. Comparing the two orderings shows whether the design increments with wrap or XORs the beat index. Starts that are not aligned also expose any carry that leaks into the upper bits. Full-page runs begin close to column 511 and include one pass longer than a whole row, which shows the 511-to-0 wrap, the absence of a last flag and the effect of terminate. A suspend window in mid-burst carries a start and a terminate that must be ignored, and a restart on top of a running burst with terminate also high checks that start wins.

// File: rtl/burst_col_pkg.sv
// Package burst_col_pkg
// Shared encodings for the burst column generator: the burst-length codes
// and the width of the length-code field. Assumes a 3-bit length code.
package burst_col_pkg;

    localparam int LEN_CODE_W = 3;

    typedef enum logic [LEN_CODE_W-1:0] {
        BLEN_1    = 3'd0,
        BLEN_2    = 3'd1,
        BLEN_4    = 3'd2,
        BLEN_8    = 3'd3,
        BLEN_PAGE = 3'd7
    } blen_code_e;

endpackage

// File: rtl/burst_len_decode.sv
// Module burst_len_decode
// Turns a burst-length code into a mask of the column bits that change
// during the burst, plus a full-page flag. Any code that is not listed
// is treated as length 1. Purely combinational.
module burst_len_decode
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [LEN_CODE_W-1:0] code_i,
    output logic [COL_W-1:0]      mask_o,
    output logic                  page_o
);

    localparam int LG_W = $clog2(COL_W + 1);

    logic [LG_W-1:0] span_lg;

    // Map the code to log2 of the burst length and the page flag.
    always_comb begin
        span_lg = '0;
        page_o  = 1'b0;
        case (blen_code_e'(code_i))
            BLEN_2:    span_lg = LG_W'(1);
            BLEN_4:    span_lg = LG_W'(2);
            BLEN_8:    span_lg = LG_W'(3);
            BLEN_PAGE: page_o  = 1'b1;
            default:   span_lg = '0;
        endcase
    end

    // One mask bit per column bit: set when that bit moves during the burst.
    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        assign mask_o[i] = page_o | (LG_W'(i) < span_lg);
    end

endmodule

// File: rtl/burst_beat_ctr.sv
// Module burst_beat_ctr
// Holds the state of the burst: the captured start column, the mask of
// moving bits, the mode bits, the beat index and the valid flag. It also
// produces the last-beat flag. Assumes the beat index never goes past the
// mask on a fixed burst and wraps freely across COL_W bits on a full page.
module burst_beat_ctr #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             page_i,
    input  logic             ilv_i,
    input  logic             hold_i,
    input  logic             term_i,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] beat_o,
    output logic [COL_W-1:0] mask_o,
    output logic             ilv_o,
    output logic             valid_o,
    output logic             last_o
);

    logic page_q;

    // Burst state update: freeze on hold, load on start, otherwise step or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o  <= '0;
            beat_o  <= '0;
            mask_o  <= '0;
            ilv_o   <= 1'b0;
            page_q  <= 1'b0;
            valid_o <= 1'b0;
        end else if (hold_i) begin
            base_o  <= base_o;
        end else if (start_i) begin
            base_o  <= start_col_i;
            beat_o  <= '0;
            mask_o  <= mask_i;
            ilv_o   <= ilv_i & ~page_i;
            page_q  <= page_i;
            valid_o <= 1'b1;
        end else if (valid_o) begin
            if (term_i || last_o) begin
                valid_o <= 1'b0;
            end else begin
                beat_o  <= beat_o + COL_W'(1);
            end
        end
    end

    // Final beat of a fixed burst: the index has reached the mask.
    always_comb begin
        last_o = valid_o && !page_q && (beat_o == mask_o);
    end

endmodule

// File: rtl/burst_addr_map.sv
// Module burst_addr_map
// Combines the start column with the beat index. Bits outside the mask
// keep the start column's value. Bits inside the mask take either the
// sum (sequential order) or the XOR (interleaved order). Purely combinational.
module burst_addr_map #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] seq_sum;
    logic [COL_W-1:0] ilv_xor;

    // Candidate addresses for the two orderings.
    always_comb begin
        seq_sum = base_i + beat_i;
        ilv_xor = base_i ^ beat_i;
    end

    // Per-bit select between the held start bit and the moving bit.
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        assign col_o[i] = !mask_i[i] ? base_i[i] :
                          (ilv_i ? ilv_xor[i] : seq_sum[i]);
    end

endmodule

// File: rtl/burst_col_gen.sv
// Module burst_col_gen (top)
// Generates the column address sequence of one SDRAM burst. The burst
// starts with a pulse and presents one column per clock. It covers fixed
// lengths 1/2/4/8 in sequential or interleaved order and full-page bursts
// that wrap across the row until terminated. Assumes that the caller holds
// start and terminate for one cycle each, and that a row has 2**COL_W columns.
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [COL_W-1:0]      start_col_i,
    input  logic [LEN_CODE_W-1:0] len_code_i,
    input  logic                  ilv_i,
    input  logic                  hold_i,
    input  logic                  term_i,
    output logic [COL_W-1:0]      col_o,
    output logic                  valid_o,
    output logic                  last_o
);

    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] beat_q;
    logic [COL_W-1:0] mask_q;
    logic             ilv_q;

    burst_len_decode #(.COL_W(COL_W)) u_dec (
        .code_i (len_code_i),
        .mask_o (dec_mask),
        .page_o (dec_page)
    );

    burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .mask_i      (dec_mask),
        .page_i      (dec_page),
        .ilv_i       (ilv_i),
        .hold_i      (hold_i),
        .term_i      (term_i),
        .base_o      (base_q),
        .beat_o      (beat_q),
        .mask_o      (mask_q),
        .ilv_o       (ilv_q),
        .valid_o     (valid_o),
        .last_o      (last_o)
    );

    burst_addr_map #(.COL_W(COL_W)) u_map (
        .base_i (base_q),
        .beat_i (beat_q),
        .mask_i (mask_q),
        .ilv_i  (ilv_q),
        .col_o  (col_o)
    );

endmodule

// File: rtl/burst_col_chk.sv
// Module burst_col_chk
// Port-level temporal checks for burst_col_gen. It is attached to every
// instance of the top module by the bind statement at the end of this file.
module burst_col_chk #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic             hold_i,
    input logic             term_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o
);

    // R2: a start taken without hold shows its column on the next cycle.
    p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !hold_i |=> valid_o && (col_o == $past(start_col_i)));

    // R3: after the final beat the burst ends unless a new one starts.
    p_last_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && last_o && !hold_i && !start_i |=> !valid_o);

    // R7: the last flag only appears inside a burst.
    p_last_in_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R8: terminate without start ends the burst.
    p_term_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        term_i && !start_i && !hold_i |=> !valid_o);

    // R9: hold freezes every output.
    p_hold_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(col_o) && $stable(valid_o) && $stable(last_o));

endmodule

bind burst_col_gen burst_col_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .hold_i      (hold_i),
    .term_i      (term_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o)
);

// File: tb/sim_burst_col_gen.sv
`timescale 1ns/100ps
// Scoreboard bench for burst_col_gen. Driver tasks push expected beats into
// a queue. A monitor samples 1 ns after each rising edge and compares.
module sim_burst_col_gen;

    localparam int COL_W = 9;
    localparam int NCOL  = 512;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start_i;
    logic [COL_W-1:0] start_col_i;
    logic [2:0]       len_code_i;
    logic             ilv_i;
    logic             hold_i;
    logic             term_i;
    logic [COL_W-1:0] col_o;
    logic             valid_o;
    logic             last_o;

    typedef struct {
        int    col;
        bit    last;
        string req;
    } beat_t;

    beat_t exp_q[$];
    int    checks = 0;
    int    errors = 0;
    int    prev_col = 0;
    bit    prev_valid = 1'b0;
    bit    prev_last = 1'b0;

    always #2.5 clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) u0 (
        .clk (clk), .rst_n (rst_n), .start_i (start_i),
        .start_col_i (start_col_i), .len_code_i (len_code_i),
        .ilv_i (ilv_i), .hold_i (hold_i), .term_i (term_i),
        .col_o (col_o), .valid_o (valid_o), .last_o (last_o)
    );

    // Record one comparison.
    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Burst length from the code; 0 stands for full page.
    function automatic int code_len(int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            7: return 0;
            default: return 1;
        endcase
    endfunction

    // Expected column of beat k, worked out from the requirements.
    function automatic int exp_col(int st, int k, int code, bit ilv);
        int n;
        int m;
        n = code_len(code);
        if (n == 0) return (st + k) % NCOL;
        m = n - 1;
        if (ilv) return (st ^ (k & m)) & (NCOL - 1);
        return ((st & ~m) | ((st + k) & m)) & (NCOL - 1);
    endfunction

    // Push the first 'count' expected beats of a burst.
    task automatic push_beats(int st, int code, bit ilv, int count, string req);
        int n;
        beat_t b;
        n = code_len(code);
        for (int k = 0; k < count; k++) begin
            b.col  = exp_col(st, k, code, ilv);
            b.last = (n != 0) && (k == n - 1);
            b.req  = req;
            exp_q.push_back(b);
        end
    endtask

    // Run one complete fixed-length burst and check that it ends.
    task automatic fixed_burst(int st, int code, bit ilv, string req);
        int n;
        n = code_len(code);
        @(negedge clk);
        start_i = 1'b1; start_col_i = COL_W'(st); len_code_i = 3'(code); ilv_i = ilv;
        push_beats(st, code, ilv, n, req);
        @(negedge clk);
        start_i = 1'b0;
        repeat (n) @(negedge clk);
        chk({req, "/R3 end"}, int'(valid_o), 0);
        chk({req, "/R3 drained"}, exp_q.size(), 0);
    endtask

    // Run a full-page burst for 'count' beats, then terminate it.
    task automatic page_burst(int st, bit ilv, int count);
        @(negedge clk);
        start_i = 1'b1; start_col_i = COL_W'(st); len_code_i = 3'd7; ilv_i = ilv;
        push_beats(st, 7, ilv, count, "R6");
        @(negedge clk);
        start_i = 1'b0;
        repeat (count - 1) @(negedge clk);
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        chk("R8 page term", int'(valid_o), 0);
        chk("R6 drained", exp_q.size(), 0);
    endtask

    // Monitor: compare each valid beat, and check stability during hold.
    initial begin
        beat_t b;
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                if (hold_i) begin
                    chk("R9 col frozen", int'(col_o), prev_col);
                    chk("R9 valid frozen", int'(valid_o), int'(prev_valid));
                    chk("R9 last frozen", int'(last_o), int'(prev_last));
                end else if (valid_o) begin
                    if (exp_q.size() == 0) begin
                        chk("R3 unexpected beat", int'(valid_o), 0);
                    end else begin
                        b = exp_q.pop_front();
                        chk(b.req, int'(col_o), b.col);
                        chk({b.req, "/R7 last"}, int'(last_o), int'(b.last));
                    end
                end
                prev_col   = int'(col_o);
                prev_valid = valid_o;
                prev_last  = last_o;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Stimulus.
    initial begin
        rst_n = 1'b0; start_i = 1'b0; start_col_i = '0; len_code_i = '0;
        ilv_i = 1'b0; hold_i = 1'b0; term_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 col", int'(col_o), 0);
        chk("R1 valid", int'(valid_o), 0);
        chk("R1 last", int'(last_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", int'(valid_o), 0);

        // R3: length 1 and the reserved codes
        fixed_burst(37, 0, 1'b0, "R3");
        fixed_burst(200, 4, 1'b0, "R3");
        fixed_burst(201, 5, 1'b1, "R3");
        fixed_burst(202, 6, 1'b0, "R3");

        // R4: sequential wrap inside the aligned block
        for (int c = 1; c <= 3; c++) begin
            fixed_burst(0, c, 1'b0, "R4");
            fixed_burst(13, c, 1'b0, "R4");
            fixed_burst(511, c, 1'b0, "R4");
            fixed_burst(250, c, 1'b0, "R4");
        end

        // R5: interleaved order
        for (int c = 1; c <= 3; c++) begin
            fixed_burst(0, c, 1'b1, "R5");
            fixed_burst(13, c, 1'b1, "R5");
            fixed_burst(511, c, 1'b1, "R5");
            fixed_burst(250, c, 1'b1, "R5");
        end

        // R6: full page with wrap, ordering bit ignored
        page_burst(500, 1'b1, 20);
        page_burst(3, 1'b0, 514);

        // R8: terminate while idle has no effect
        @(negedge clk);
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        chk("R8 idle term", int'(valid_o), 0);
        @(negedge clk);
        chk("R8 idle term later", int'(valid_o), 0);

        // R9: hold in mid-burst, with start and terminate to be ignored
        @(negedge clk);
        start_i = 1'b1; start_col_i = 9'd13; len_code_i = 3'd3; ilv_i = 1'b0;
        push_beats(13, 3, 1'b0, 8, "R9");
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        hold_i = 1'b1; start_i = 1'b1; start_col_i = 9'd200; term_i = 1'b1;
        repeat (3) @(negedge clk);
        hold_i = 1'b0; start_i = 1'b0; term_i = 1'b0;
        repeat (7) @(negedge clk);
        chk("R9 end after resume", int'(valid_o), 0);
        chk("R9 drained", exp_q.size(), 0);

        // R10: restart over a running burst, terminate also high
        @(negedge clk);
        start_i = 1'b1; start_col_i = 9'd40; len_code_i = 3'd3; ilv_i = 1'b1;
        push_beats(40, 3, 1'b1, 3, "R10");
        @(negedge clk);
        start_i = 1'b0;
        repeat (2) @(negedge clk);
        start_i = 1'b1; start_col_i = 9'd77; len_code_i = 3'd2; ilv_i = 1'b0; term_i = 1'b1;
        push_beats(77, 2, 1'b0, 4, "R10");
        @(negedge clk);
        start_i = 1'b0; term_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 end", int'(valid_o), 0);
        chk("R10 drained", exp_q.size(), 0);

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule